// File: doc/BRIEF.md
# Failed Posted Write Capture Queue

This block keeps a short record of posted write requests that could not be completed. Each time the surrounding logic reports a failure, the block stores the requester's 16-bit source ID (bus and node number) and the 48-bit destination offset the requester tried to reach. The record is kept in a small first-in first-out store. The oldest record stays visible to software through two 32-bit read-only data registers on a simple register bus.

An event bit is set whenever a record is at the head of the store. Together with a mask bit, it drives an interrupt line. Software reads the two data registers and then writes 1 to the clear bit. Reading the data registers does not retire the record; the clear write does. The event then drops for one cycle. If more records are waiting, the event is set again, so each stored failure produces its own interrupt until the store is empty.

Top module: `pwErrQueue`

## Requirements
- R1: A failure reported while the store holds fewer than 4 records is stored. In the next cycle, bit 8 of the event register (address 0x80) reads 1.
- R2: Address 0x38 returns, in bits 31:0, the low 32 bits of the destination offset of the oldest stored record.
- R3: Address 0x3C returns the oldest record's source ID in bits 31:16 and the upper 16 offset bits in bits 15:0.
- R4: Reading any register changes neither the stored records nor the event bit.
- R5: Writing address 0x84 with bit 8 set, while the event bit is 1, retires the head record. The event bit then reads 0 for one cycle. It reads 1 again in the following cycle if records remain, and the next-oldest record is then at the head.
- R6: While the store is empty, the event bit stays 0 and the interrupt stays low. A write to 0x84 in this state has no effect.
- R7: A write to 0x84 with bit 8 at 0 retires nothing and leaves the event bit set.
- R8: The store holds 4 records and returns them oldest first. A failure reported while it is full, with no retirement in the same cycle, is dropped and sets the sticky overflow flag, bit 9 of 0x80.
- R9: Writing address 0x84 with bit 9 set clears the overflow flag and does not affect the event bit.
- R10: A failure reported in the same cycle as a retirement is stored and the record count stays unchanged. This also holds when the store is full, and no overflow is flagged in that case.
- R11: The interrupt output equals the event bit ANDed with bit 8 of the read/write mask register at 0x88.
- R12: After reset, the event bit, the overflow flag, the mask bit and the interrupt are all 0. The data registers are undefined until the first capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| failValid | input | 1 | One-cycle report of a failed posted write |
| failSrcId | input | 16 | Source ID of the failed requester |
| failOffset | input | 48 | Destination offset of the failed write |
| regAddr | input | 8 | Register byte address |
| regWrEn | input | 1 | Register write strobe |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data for regAddr (combinational) |
| irqOut | output | 1 | Interrupt request |

## Verification
On every cycle, assertions check three things. The record count never exceeds the depth. A capture that coincides with a retirement leaves the count unchanged. The event bit is consistent with the store: it is only set when records exist, it holds until software clears it, it re-arms after a retirement that leaves records behind, and it stays low while the store is empty. Other behaviour only the bench scenarios can show: that records come back oldest first with the correct field packing, that overflow records are dropped, and that reads and zero-valued clear writes have no side effects.

// File: rtl/pwErrPkg.sv
package pwErrPkg;
  localparam int SRC_W = 16;
  localparam int OFF_W = 48;

  typedef struct packed {
    logic [SRC_W-1:0] srcId;
    logic [OFF_W-1:0] offset;
  } errRec_t;

  typedef struct packed {
    logic push;
    logic pop;
  } qStrobe_t;
endpackage

// File: rtl/pwErrData.sv
module pwErrData
  import pwErrPkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic     clk,
  input  logic     rstN,
  input  qStrobe_t strb,
  input  errRec_t  inRec,
  output errRec_t  headRec,
  output logic     empty,
  output logic     full
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);

  errRec_t store [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic [CNT_W-1:0] count;

  genvar g;
  generate
    for (g = 0; g < DEPTH; g++) begin : gSlot
      always_ff @(posedge clk) begin
        if (strb.push && wrPtr == PTR_W'(g)) store[g] <= inRec;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (strb.push) wrPtr <= (wrPtr == LAST_PTR) ? '0 : wrPtr + 1'b1;
      if (strb.pop)  rdPtr <= (rdPtr == LAST_PTR) ? '0 : rdPtr + 1'b1;
      case ({strb.push, strb.pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign headRec = store[rdPtr];
  assign empty   = (count == '0);
  assign full    = (count == DEPTH_C);

  // R8
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    count <= DEPTH_C);

  // R8
  no_push_full_chk: assert property (@(posedge clk) disable iff (!rstN)
    (full && strb.push) |-> strb.pop);

  // R6
  no_pop_empty_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.pop |-> !empty);

  // R10
  swap_count_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.push && strb.pop) |=> (count == $past(count)));
endmodule

// File: rtl/pwErrCtl.sv
module pwErrCtl
  import pwErrPkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int EVT_BIT = 8,
  parameter int OVF_BIT = 9
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              failValid,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic [31:0]       regWrData,
  input  errRec_t           headRec,
  input  logic              empty,
  input  logic              full,
  output qStrobe_t          strb,
  output logic [31:0]       regRdData,
  output logic              irqOut
);
  localparam logic [ADDR_W-1:0] LO_ADDR   = ADDR_W'('h38);
  localparam logic [ADDR_W-1:0] HI_ADDR   = ADDR_W'('h3C);
  localparam logic [ADDR_W-1:0] EVT_ADDR  = ADDR_W'('h80);
  localparam logic [ADDR_W-1:0] CLR_ADDR  = ADDR_W'('h84);
  localparam logic [ADDR_W-1:0] MASK_ADDR = ADDR_W'('h88);

  logic evtBit, ovfFlag, maskBit;
  logic clrWr, maskWr, ovfSet;
  logic unusedBits;

  assign unusedBits = ^regWrData;
  assign clrWr  = regWrEn && (regAddr == CLR_ADDR);
  assign maskWr = regWrEn && (regAddr == MASK_ADDR);

  always_comb begin
    strb.pop  = clrWr && regWrData[EVT_BIT] && evtBit;
    strb.push = failValid && (!full || strb.pop);
    ovfSet    = failValid && full && !strb.pop;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      evtBit  <= 1'b0;
      ovfFlag <= 1'b0;
      maskBit <= 1'b0;
    end else begin
      evtBit  <= strb.pop ? 1'b0 : (evtBit | strb.push | !empty);
      ovfFlag <= ovfSet | (ovfFlag & !(clrWr && regWrData[OVF_BIT]));
      if (maskWr) maskBit <= regWrData[EVT_BIT];
    end
  end

  always_comb begin
    regRdData = '0;
    case (regAddr)
      LO_ADDR:   regRdData = headRec.offset[31:0];
      HI_ADDR:   regRdData = {headRec.srcId, headRec.offset[47:32]};
      EVT_ADDR:  begin
        regRdData[EVT_BIT] = evtBit;
        regRdData[OVF_BIT] = ovfFlag;
      end
      MASK_ADDR: regRdData[EVT_BIT] = maskBit;
      default:   regRdData = '0;
    endcase
  end

  assign irqOut = evtBit & maskBit;

  // R1
  evt_has_head_chk: assert property (@(posedge clk) disable iff (!rstN)
    evtBit |-> !empty);

  // R5
  evt_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (evtBit && !strb.pop) |=> evtBit);

  // R5
  evt_rearm_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(strb.pop) && !empty) |=> evtBit);

  // R6
  empty_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (empty && !failValid && !evtBit) |=> !evtBit);
endmodule

// File: rtl/pwErrQueue.sv
module pwErrQueue
  import pwErrPkg::*;
#(
  parameter int DEPTH = 4,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              failValid,
  input  logic [15:0]       failSrcId,
  input  logic [47:0]       failOffset,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic [31:0]       regWrData,
  output logic [31:0]       regRdData,
  output logic              irqOut
);
  qStrobe_t strb;
  errRec_t  inRec, headRec;
  logic     empty, full;

  assign inRec = '{srcId: failSrcId, offset: failOffset};

  pwErrCtl #(.ADDR_W(ADDR_W)) uCtl (
    .clk(clk), .rstN(rstN), .failValid(failValid),
    .regAddr(regAddr), .regWrEn(regWrEn), .regWrData(regWrData),
    .headRec(headRec), .empty(empty), .full(full),
    .strb(strb), .regRdData(regRdData), .irqOut(irqOut)
  );

  pwErrData #(.DEPTH(DEPTH)) uData (
    .clk(clk), .rstN(rstN), .strb(strb), .inRec(inRec),
    .headRec(headRec), .empty(empty), .full(full)
  );
endmodule

// File: tb/sim_pwErrQueue.sv
module sim_pwErrQueue;
  logic clk = 0, rstN = 0, failValid = 0, regWrEn = 0;
  logic [15:0] failSrcId = '0;
  logic [47:0] failOffset = '0;
  logic [7:0]  regAddr = '0;
  logic [31:0] regWrData = '0, regRdData;
  logic irqOut;
  int checks = 0, failures = 0, cyc = 0;
  bit done = 0;

  always #10 clk = ~clk;

  pwErrQueue u0 (.*);

  function automatic logic [15:0] srcOf(int k);
    return 16'h0200 + 16'(k) * 16'h0101;
  endfunction
  function automatic logic [47:0] offOf(int k);
    return {16'h8000 ^ (16'(k) * 16'h1111), 32'hDEAD0000 + 32'(k) * 32'h00010003};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    regAddr = a; #1; d = regRdData;
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk); regAddr = a; regWrData = d; regWrEn = 1;
    @(negedge clk); regWrEn = 0;
  endtask

  task automatic report(int k);
    @(negedge clk); failValid = 1; failSrcId = srcOf(k); failOffset = offOf(k);
    @(negedge clk); failValid = 0;
  endtask

  task automatic bothOp(int k);
    @(negedge clk); failValid = 1; failSrcId = srcOf(k); failOffset = offOf(k);
    regAddr = 8'h84; regWrData = 32'h100; regWrEn = 1;
    @(negedge clk); failValid = 0; regWrEn = 0;
  endtask

  task automatic headIs(string req, int k);
    logic [31:0] d;
    logic [47:0] o;
    o = offOf(k);
    rd(8'h38, d); chk(req, d, o[31:0]);
    rd(8'h3C, d); chk(req, d, {srcOf(k), o[47:32]});
  endtask

  task automatic popCheck(int k, bit more);
    logic [31:0] d;
    headIs("R2/R3 head", k);
    rd(8'h80, d); chk("R5 event before pop", 32'(d[8]), 1);
    wr(8'h84, 32'h100);
    rd(8'h80, d); chk("R5 event gap", 32'(d[8]), 0);
    @(negedge clk);
    rd(8'h80, d); chk("R5 rearm", 32'(d[8]), 32'(more));
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      done = 1; failures++; checks++;
      $display("FAIL watchdog actual=%0d expected<100000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R12 reset state
    rd(8'h80, d); chk("R12 event/ovf", d, 0);
    rd(8'h88, d); chk("R12 mask", d, 0);
    chk("R12 irq", 32'(irqOut), 0);
    wr(8'h88, 32'h100);
    rd(8'h88, d); chk("R11 mask readback", d, 32'h100);
    // R6 clear while empty
    wr(8'h84, 32'h100);
    repeat (3) @(negedge clk);
    rd(8'h80, d); chk("R6 empty quiet", d, 0);
    chk("R6 irq low", 32'(irqOut), 0);
    // R1 capture
    report(0);
    rd(8'h80, d); chk("R1 event set", d, 32'h100);
    chk("R11 irq on", 32'(irqOut), 1);
    headIs("R2/R3 first", 0);
    // R4 reads no side effect
    for (int i = 0; i < 5; i++) begin
      rd(8'h38, d); rd(8'h3C, d); @(negedge clk);
    end
    headIs("R4 head kept", 0);
    rd(8'h80, d); chk("R4 event kept", d, 32'h100);
    // R7 zero clear
    wr(8'h84, 32'h0);
    @(negedge clk);
    rd(8'h80, d); chk("R7 event kept", d, 32'h100);
    headIs("R7 head kept", 0);
    // R11 mask off
    wr(8'h88, 32'h0);
    chk("R11 irq masked", 32'(irqOut), 0);
    wr(8'h88, 32'h100);
    chk("R11 irq unmasked", 32'(irqOut), 1);
    popCheck(0, 0);
    repeat (3) @(negedge clk);
    rd(8'h80, d); chk("R6 stays empty", d, 0);
    chk("R6 irq low after drain", 32'(irqOut), 0);
    // R8 fill, overflow, order
    for (int k = 1; k <= 4; k++) report(k);
    rd(8'h80, d); chk("R8 no ovf yet", 32'(d[9]), 0);
    report(5);
    rd(8'h80, d); chk("R8 ovf set", 32'(d[9]), 1);
    wr(8'h84, 32'h200);
    rd(8'h80, d); chk("R9 ovf cleared, event kept", d, 32'h100);
    for (int k = 1; k <= 4; k++) popCheck(k, k != 4);
    // R10 swap with partial queue
    report(6); report(7);
    bothOp(8);
    headIs("R10 head after swap", 7);
    @(negedge clk);
    popCheck(7, 1);
    popCheck(8, 0);
    // R10 swap with full queue
    for (int k = 9; k <= 12; k++) report(k);
    bothOp(13);
    rd(8'h80, d); chk("R10 no ovf on full swap", 32'(d[9]), 0);
    @(negedge clk);
    for (int k = 10; k <= 13; k++) popCheck(k, k != 13);
    repeat (2) @(negedge clk);
    rd(8'h80, d); chk("R6 final empty", d, 0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule